// File: doc/BRIEF.md
# Sync-Restartable Clock Post-Divider

This block divides a fast oscillator clock by a programmable integer ratio. The ratio is counted in half oscillator periods, so odd ratios give a true half-period-accurate output. The divider acts on both oscillator edges. A posedge engine works out the output level for the two half-periods that each oscillator cycle contains. The falling-edge half is carried through a negedge register, and the oscillator level selects which of the two half-period values drives the output.

An asynchronous phase-alignment input realigns the output. Its active edge is chosen by a polarity bit. The inactive edge drains the divider: the current high phase runs to completion, then the output parks low while the oscillator keeps running. The active edge restarts the count from zero after a fixed latency of `2*SYNC_STAGES` half-periods. That latency is counted from the first oscillator edge, of either sense, that follows the active edge, so the output phase follows the input at half-period resolution. A shutdown bit holds the output low and masks the alignment input. Clearing it starts a fresh cycle.

Top module: `pdiv_top`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low.
- R2: With ratio N, each output cycle is high for ceil(N/2) half oscillator periods, then low for floor(N/2). A ratio below 2 acts as 2.
- R3: A new ratio takes effect only at the start of the next output cycle. Every complete output cycle has the high/low lengths of either the old ratio or the new ratio.
- R4: `sync_pol`=1 makes a rising `sync_in` edge active. `sync_pol`=0 makes a falling edge active. The other edge is the inactive one.
- R5: An inactive edge stops the output at low level, but only after the high phase in progress has completed. No shortened high phase appears, and the output then stays low.
- R6: When stopped, the first high half-period after an active edge begins exactly 2*SYNC_STAGES half-periods (4 by default) after the first oscillator edge that follows the active edge, and it lasts a full ceil(N/2) half-periods.
- R7: The active edge is captured on whichever oscillator edge comes first, rising or falling, so a restart can begin on a falling oscillator edge as well as on a rising one.
- R8: If the active level returns before the stop completes, the stop still completes without shortening the high phase, and the output then restarts and divides normally.
- R9: While `shutdown` is high, `clk_out` is low and `sync_in` transitions are ignored. After it is cleared, the first half-period that starts at the next rising oscillator edge is high, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W | Divide ratio N in half oscillator periods |
| sync_pol | input | 1 | 1: rising edge of sync_in is active; 0: falling edge is active |
| sync_in | input | 1 | Asynchronous phase-alignment input |
| shutdown | input | 1 | Holds the output low and masks sync_in |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that `div_ratio`, `sync_pol` and `shutdown` are quasi-static values sampled on rising oscillator edges. They also assume that `sync_pol` changes only while `shutdown` is high, because flipping the polarity turns the current level into an edge. The stimulus therefore changes these inputs one nanosecond after a clock edge and switches polarity only inside a shutdown window. It also keeps every `sync_in` level for at least two half-periods so that both synchronizer chains see it. The assertions further take the oscillator to be free-running with no missing edges, and the bench's clock generator never pauses.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;
   typedef enum logic [1:0] {
      PD_RUN   = 2'd0,
      PD_DRAIN = 2'd1,
      PD_HALT  = 2'd2
   } pd_mode_e;
   localparam int PD_SLOTS = 2;
endpackage

// File: rtl/pdiv_sync.sv
`timescale 1ns/1ps
module pdiv_sync #(
   parameter int STAGES   = 2,
   parameter bit NEG_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pdiv_sync needs at least two stages");
      end
      if (NEG_EDGE) begin : g_neg
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], d_i};
         end
      end else begin : g_pos
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pdiv_engine.sv
`timescale 1ns/1ps
module pdiv_engine
   import pdiv_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio_i,
   input  logic             pol_i,
   input  logic             p_sync_i,
   input  logic             n_sync_i,
   input  logic             shut_i,
   output logic             slot0_o,
   output logic             slot1_o
);
   localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

   logic [DIV_W-1:0] cnt_q, nlat_q, cnt_d, nlat_d, ratio_c;
   pd_mode_e         mode_q, mode_d;
   logic             pend_q, pend_d, par_q, par_d, nprev_q;
   logic             slot0_q, slot1_q;
   logic [PD_SLOTS-1:0] slot_v;
   logic             p_act, n_act, n_fall, n_rise;

   assign ratio_c = (ratio_i < MIN_RATIO) ? MIN_RATIO : ratio_i;
   assign p_act   = ~(p_sync_i ^ pol_i);
   assign n_act   = ~(n_sync_i ^ pol_i);
   assign n_fall  = nprev_q & ~n_act;
   assign n_rise  = ~nprev_q & n_act;

   always_comb begin
      logic             v;
      logic             hit;
      logic [DIV_W:0]   half_w;
      logic [DIV_W:0]   nxt_w;
      cnt_d  = cnt_q;
      nlat_d = nlat_q;
      mode_d = mode_q;
      pend_d = pend_q;
      par_d  = par_q;
      slot_v = '0;
      v      = 1'b0;
      hit    = 1'b0;
      half_w = '0;
      nxt_w  = '0;
      if (shut_i) begin
         cnt_d  = '0;
         nlat_d = ratio_c;
         mode_d = PD_RUN;
         pend_d = 1'b0;
         par_d  = 1'b0;
      end else begin
         if (n_fall) begin
            pend_d = 1'b0;
            if (mode_d == PD_RUN) mode_d = PD_DRAIN;
         end
         if (n_rise && (mode_d != PD_RUN)) begin
            pend_d = 1'b1;
            par_d  = ~p_act;
         end
         for (int i = 0; i < PD_SLOTS; i++) begin
            hit = (mode_d == PD_HALT) && pend_d && (par_d == (i == 1));
            if (hit) begin
               cnt_d  = '0;
               nlat_d = ratio_c;
               mode_d = PD_RUN;
               pend_d = 1'b0;
            end
            half_w = ({1'b0, nlat_d} + 1'b1) >> 1;
            v = (mode_d != PD_HALT) && ({1'b0, cnt_d} < half_w);
            if ((mode_d == PD_DRAIN) && !v) mode_d = PD_HALT;
            slot_v[i] = v;
            if (mode_d != PD_HALT) begin
               nxt_w = {1'b0, cnt_d} + 1'b1;
               if (nxt_w >= {1'b0, nlat_d}) begin
                  cnt_d  = '0;
                  nlat_d = ratio_c;
               end else begin
                  cnt_d = nxt_w[DIV_W-1:0];
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         nlat_q  <= MIN_RATIO;
         mode_q  <= PD_RUN;
         pend_q  <= 1'b0;
         par_q   <= 1'b0;
         nprev_q <= 1'b0;
         slot0_q <= 1'b0;
         slot1_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         nlat_q  <= nlat_d;
         mode_q  <= mode_d;
         pend_q  <= pend_d;
         par_q   <= par_d;
         nprev_q <= n_act;
         slot0_q <= shut_i ? 1'b0 : slot_v[0];
         slot1_q <= shut_i ? 1'b0 : slot_v[1];
      end
   end

   assign slot0_o = slot0_q;
   assign slot1_o = slot1_q;

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q < nlat_q) && (nlat_q >= MIN_RATIO));

   // R5
   halt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PD_HALT) |-> !slot1_q);

   // R9
   shut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shut_i |=> (!slot0_q && !slot1_q && (mode_q == PD_RUN)));

   // R6
   restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q == PD_HALT) && (mode_q == PD_RUN) && !$past(shut_i))
         |-> (slot0_q || slot1_q));
endmodule

// File: rtl/pdiv_outstage.sv
`timescale 1ns/1ps
module pdiv_outstage (
   input  logic clk,
   input  logic rst_n,
   input  logic slot0_i,
   input  logic slot1_i,
   output logic clk_o
);
   logic slot1_n;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) slot1_n <= 1'b0;
      else        slot1_n <= slot1_i;
   end

   assign clk_o = clk ? slot0_i : slot1_n;

   // R1
   reset_low_chk: assert property (@(negedge clk)
      !rst_n |-> !slot1_n);
endmodule

// File: rtl/pdiv_top.sv
`timescale 1ns/1ps
module pdiv_top #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             osc_clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic             sync_pol,
   input  logic             sync_in,
   input  logic             shutdown,
   output logic             clk_out
);
   // Restart latency in half oscillator periods, from capture edge to first high half.
   localparam int RESTART_HALVES = 2 * SYNC_STAGES;

   logic p_sync, n_sync, slot0, slot1;

   generate
      if (DIV_W < 2) begin : g_bad_w
         $error("DIV_W must be at least 2");
      end
      if (RESTART_HALVES < 4) begin : g_bad_s
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   pdiv_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_sync_p (
      .clk(osc_clk), .rst_n(rst_n), .d_i(sync_in), .q_o(p_sync));

   pdiv_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_sync_n (
      .clk(osc_clk), .rst_n(rst_n), .d_i(sync_in), .q_o(n_sync));

   pdiv_engine #(.DIV_W(DIV_W)) u_engine (
      .clk(osc_clk), .rst_n(rst_n), .ratio_i(div_ratio), .pol_i(sync_pol),
      .p_sync_i(p_sync), .n_sync_i(n_sync), .shut_i(shutdown),
      .slot0_o(slot0), .slot1_o(slot1));

   pdiv_outstage u_out (
      .clk(osc_clk), .rst_n(rst_n), .slot0_i(slot0), .slot1_i(slot1),
      .clk_o(clk_out));
endmodule

// File: tb/pdiv_top_tb.sv
`timescale 1ns/1ps
module pdiv_top_tb;
   localparam int DW = 8;
   localparam int SS = 2;

   logic          osc_clk = 1'b0;
   logic          rst_n   = 1'b0;
   logic [DW-1:0] div_ratio = 8'd4;
   logic          sync_pol = 1'b1;
   logic          sync_in  = 1'b1;
   logic          shutdown = 1'b1;
   logic          clk_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   pdiv_top #(.DIV_W(DW), .SYNC_STAGES(SS)) u_dut (
      .osc_clk(osc_clk), .rst_n(rst_n), .div_ratio(div_ratio),
      .sync_pol(sync_pol), .sync_in(sync_in), .shutdown(shutdown),
      .clk_out(clk_out));

   always #5 osc_clk = ~osc_clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Sample the output in the middle of each of the next n half-periods.
   task automatic grab(input int n, ref logic q[$]);
      q.delete();
      repeat (n) begin
         @(osc_clk);
         #2.5;
         q.push_back(clk_out);
      end
   endtask

   task automatic runs_of(ref logic q[$], ref logic rv[$], ref int rl[$]);
      rv.delete(); rl.delete();
      for (int i = 0; i < q.size(); i++) begin
         if (i == 0 || q[i] != q[i-1]) begin
            rv.push_back(q[i]); rl.push_back(1);
         end else begin
            rl[rl.size()-1]++;
         end
      end
   endtask

   // Interior runs must match hi/lo exactly.
   task automatic check_pattern(input int n, input string req);
      logic q[$]; logic rv[$]; int rl[$];
      int hi = (n + 1) / 2;
      int lo = n / 2;
      int bad = 0;
      grab(12 * n + 8, q);
      runs_of(q, rv, rl);
      for (int i = 1; i < rv.size() - 1; i++)
         if (rl[i] != (rv[i] ? hi : lo)) bad++;
      chk(bad == 0 && rv.size() > 4, req, bad, 0);
   endtask

   task automatic at_pos(input int ns);
      @(posedge osc_clk); #(ns);
   endtask

   // Stop with an inactive edge; check that no high run is shortened.
   task automatic stop_and_check(input logic inactive, input int n, input string req);
      logic q[$]; logic rv[$]; int rl[$];
      int bad = 0;
      at_pos(1);
      sync_in = inactive;
      grab(2 * n + 40, q);
      runs_of(q, rv, rl);
      for (int i = 1; i < rv.size() - 1; i++)
         if (rv[i] && rl[i] != (n + 1) / 2) bad++;
      chk(bad == 0, {req, " no shortened high"}, bad, 0);
      chk(rv[rv.size()-1] == 1'b0 && rl[rl.size()-1] >= 20, {req, " parked low"},
          rl[rl.size()-1], 20);
   endtask

   // Active edge just after a rising (neg_cap=1) or falling (neg_cap=0) osc edge.
   task automatic restart_at(input logic active, input bit neg_cap, input int n, input string req);
      int hi_cnt = 0;
      if (neg_cap) @(posedge osc_clk); else @(negedge osc_clk);
      #1 sync_in = active;
      // capture edge 4 ns later; first high half starts 2*SS halves after it
      #(4.0 + SS * 10.0 - 2.5);
      chk(clk_out == 1'b0, {req, " low before latency"}, clk_out, 0);
      #5;
      chk(clk_out == 1'b1, {req, " high at latency"}, clk_out, 1);
      for (int i = 1; i < (n + 1) / 2; i++) begin
         #5;
         if (clk_out) hi_cnt++;
      end
      #5;
      chk(hi_cnt == (n + 1) / 2 - 1 && clk_out == 1'b0, {req, " full first high"},
          hi_cnt + 1, (n + 1) / 2);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge osc_clk);
      #2.5;
      chk(clk_out == 1'b0, "R1 low in reset", clk_out, 0);
      #5;
      chk(clk_out == 1'b0, "R1 low in reset", clk_out, 0);
      at_pos(1);
      rst_n = 1'b1;
      at_pos(1);
      shutdown = 1'b0;
   endtask

   task automatic t_divide();
      int ratios[6] = '{2, 3, 4, 5, 7, 1};
      foreach (ratios[k]) begin
         at_pos(1);
         div_ratio = DW'(ratios[k]);
         repeat (4) @(posedge osc_clk);
         check_pattern(ratios[k] < 2 ? 2 : ratios[k], "R2 divide pattern");
      end
   endtask

   task automatic t_ratio_change();
      logic q[$]; logic rv[$]; int rl[$];
      int bad = 0;
      at_pos(1);
      div_ratio = 8'd5;
      repeat (10) @(posedge osc_clk);
      fork
         grab(120, q);
         begin #37 div_ratio = 8'd8; end
      join
      runs_of(q, rv, rl);
      for (int i = 1; i < rv.size() - 2; i++) begin
         if (rv[i]) begin
            if (!((rl[i] == 3 && rl[i+1] == 2) || (rl[i] == 4 && rl[i+1] == 4))) bad++;
         end
      end
      chk(bad == 0, "R3 whole cycles only", bad, 0);
      check_pattern(8, "R3 new ratio in force");
   endtask

   task automatic t_stop_restart_pos();
      at_pos(1);
      div_ratio = 8'd9;
      repeat (6) @(posedge osc_clk);
      stop_and_check(1'b0, 9, "R5 R4 rising-active");
      restart_at(1'b1, 1'b1, 9, "R6 R7 capture on falling osc edge");
      stop_and_check(1'b0, 9, "R5 second stop");
      restart_at(1'b1, 1'b0, 9, "R6 R7 capture on rising osc edge");
      check_pattern(9, "R6 divides after restart");
   endtask

   task automatic t_polarity_neg();
      at_pos(1);
      shutdown = 1'b1;
      at_pos(1);
      sync_pol = 1'b0;
      sync_in  = 1'b0;
      div_ratio = 8'd6;
      repeat (4) @(posedge osc_clk);
      at_pos(1);
      shutdown = 1'b0;
      check_pattern(6, "R4 runs with falling-active polarity");
      stop_and_check(1'b1, 6, "R4 R5 rising edge stops");
      restart_at(1'b0, 1'b1, 6, "R4 R6 falling edge restarts");
   endtask

   task automatic t_early_return();
      logic q[$]; logic rv[$]; int rl[$];
      int bad = 0;
      int highs = 0;
      at_pos(1);
      div_ratio = 8'd9;
      repeat (8) @(posedge osc_clk);
      fork
         grab(140, q);
         begin
            #13 sync_in = 1'b1;
            #10 sync_in = 1'b0;
         end
      join
      runs_of(q, rv, rl);
      for (int i = 1; i < rv.size() - 1; i++) begin
         if (rv[i]) begin
            highs++;
            if (rl[i] != 5) bad++;
         end else if (rl[i] < 4) bad++;
      end
      chk(bad == 0, "R8 stop completes without runt", bad, 0);
      chk(highs >= 5, "R8 restarts after early return", highs, 5);
   endtask

   task automatic t_shutdown();
      logic q[$];
      int hi = 0;
      at_pos(1);
      div_ratio = 8'd4;
      repeat (4) @(posedge osc_clk);
      at_pos(1);
      shutdown = 1'b1;
      fork
         grab(40, q);
         begin
            #40 sync_in = 1'b1;
            #40 sync_in = 1'b0;
            #40 sync_in = 1'b1;
            #40 sync_in = 1'b0;
         end
      join
      for (int i = 4; i < q.size(); i++) if (q[i]) hi++;
      chk(hi == 0, "R9 low in shutdown", hi, 0);
      @(negedge osc_clk);
      #1 shutdown = 1'b0;
      #5.5;
      chk(clk_out == 1'b1, "R9 first half high", clk_out, 1);
      #5;
      chk(clk_out == 1'b1, "R9 second half high", clk_out, 1);
      #5;
      chk(clk_out == 1'b0, "R9 third half low", clk_out, 0);
      #5;
      chk(clk_out == 1'b0, "R9 fourth half low", clk_out, 0);
      check_pattern(4, "R9 sync edges in shutdown ignored");
   endtask

   initial begin
      t_reset();
      t_divide();
      t_ratio_change();
      t_stop_restart_pos();
      t_polarity_neg();
      t_early_return();
      t_shutdown();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule